// File: doc/BRIEF.md
# Multichannel Edge-Compare PWM Engine

This block drives a bank of pulse-width-modulated outputs from one shared period counter. A programmable prescaler divides the incoming oscillator-rate clock, and every divided tick advances a free-running counter of `2**CNT_W` steps. Each channel compares that counter against its own rise count and fall count. The two edges can sit anywhere in the period, so both the duty cycle and the phase of each channel are programmable. Staggering the rise counts of several channels spreads their switching edges across the period.

Every channel also has two override flags. One holds the output fully high. The other holds it fully low, and it takes priority over the first. A single polarity control inverts all outputs together. A sleep input parks the prescaler and the counter. Settings arrive on parallel configuration inputs. Rise and fall counts are captured into per-channel shadow registers only when the counter rolls over, so a change made mid-period never distorts the period in progress.

Top module: `edge_pwm_bank`

## Requirements
- R1: The period counter has `2**CNT_W` steps (4096 by default) and advances once every `eff+1` clocks, where `eff` is the effective prescale. After the first clock edge that samples `sleep` low (edge 1), `pwm_out` after edge j reflects count value `floor((j-1)/(eff+1)) mod 2**CNT_W`.
- R2: The effective prescale is `prescale` when `prescale >= PRE_MIN` (3 by default) and `PRE_MIN` otherwise. The largest value, 255, gives a period of `256 * 2**CNT_W` clocks.
- R3: When rise < fall, a channel is high for counts c with rise <= c < fall and low for every other count.
- R4: When fall < rise, the high interval wraps across rollover: the channel is high for c >= rise or c < fall. When rise == fall, the channel stays low.
- R5: A set `force_lo` bit holds its channel low, whatever the counts and `force_hi` are.
- R6: When `force_lo` is clear and `force_hi` is set, the channel is high for the whole period.
- R7: When `invert` is 1, every channel output is the complement of the level given by R3 to R6 and R9.
- R8: Rise and fall counts are captured on the clock edge where the counter rolls over from its maximum to 0, and also on every edge that samples `sleep` high. Between captures, changes on `rise_cnt` and `fall_cnt` have no effect on the outputs.
- R9: On an edge that samples `sleep` high, the prescaler and the counter are cleared and every output is driven to the value of `invert`. Synchronous reset drives every output to 0.
- R10: `pwm_out` is registered. Force flags and `invert` are sampled at a clock edge and show on the output after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Holds the prescaler and counter cleared, with outputs at their idle level |
| prescale | input | PRE_W | Prescale setting; each counter step lasts this many clocks plus one |
| invert | input | 1 | Global output polarity inversion |
| rise_cnt | input | NUM_CH*CNT_W | Per-channel count at which the output goes high; channel i in bits [i*CNT_W +: CNT_W] |
| fall_cnt | input | NUM_CH*CNT_W | Per-channel count at which the output goes low; same packing |
| force_hi | input | NUM_CH | Per-channel hold-high override |
| force_lo | input | NUM_CH | Per-channel hold-low override; dominates force_hi |
| pwm_out | output | NUM_CH | Channel outputs |

## Verification
A wrong prescaler divide or a wrong counter step moves every later output edge. It shows on the first channel edge after the fault, within one counter step of `eff+1` clocks, and it accumulates into a wrong high-time count over a full period. A shadow register loaded at the wrong moment shows as an edge at an old or new position during the period of an update, which is caught before the next rollover. A wrong override priority or a wrong inversion shows in the output one clock after the flag is sampled.

// File: rtl/edge_pwm_bank_pkg.sv
// Package: shared helpers for the edge-compare PWM bank.
// Assumes counter widths of at most 16 bits; callers zero-extend.
package edge_pwm_bank_pkg;

    typedef logic [15:0] cmp_word_t;

    // Window test: is count c inside the high interval set by rise r and fall f?
    function automatic logic pwm_in_window(input cmp_word_t c, input cmp_word_t r, input cmp_word_t f);
        if (r < f)
            return (c >= r) && (c < f);
        else if (r > f)
            return (c >= r) || (c < f);
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
// Module: prescaler plus shared period counter.
// Each counter step lasts max(prescale, PRE_MIN)+1 clocks. wrap pulses on the
// edge where the counter moves from its maximum back to zero.
// Assumes a synchronous active-low reset; sleep acts as a synchronous clear.
module pwm_timebase #(
    parameter int CNT_W   = 12,
    parameter int PRE_W   = 8,
    parameter int PRE_MIN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic [PRE_W-1:0] prescale,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [PRE_W-1:0] PRE_LOW  = PRE_W'(PRE_MIN);

    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] eff;
    logic             tick;

    // Clamp the prescale value to its lower bound.
    always_comb begin
        eff  = (prescale < PRE_LOW) ? PRE_LOW : prescale;
        tick = (div_q == eff);
        wrap = tick && (count == CNT_MAX);
    end

    // Divide the clock and step the period counter on each divided tick.
    always_ff @(posedge clk) begin
        if (!rst_n || sleep) begin
            div_q <= '0;
            count <= '0;
        end else if (tick) begin
            div_q <= '0;
            count <= count + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
// Module: one PWM channel.
// Holds shadow copies of its rise and fall counts, loaded at rollover or during
// sleep. It applies the override flags (low dominates) and the polarity, and
// registers the result. Assumes count is the shared counter register.
module pwm_channel
    import edge_pwm_bank_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             invert,
    input  logic             wrap,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] rise_in,
    input  logic [CNT_W-1:0] fall_in,
    input  logic             force_hi,
    input  logic             force_lo,
    output logic             out
);
    logic [CNT_W-1:0] rise_sh;
    logic [CNT_W-1:0] fall_sh;
    logic             level;

    // Capture new edge counts only at period boundaries or while parked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_sh <= '0;
            fall_sh <= '0;
        end else if (sleep || wrap) begin
            rise_sh <= rise_in;
            fall_sh <= fall_in;
        end
    end

    // Resolve overrides, then the compare window, for the current count.
    always_comb begin
        if (force_lo)
            level = 1'b0;
        else if (force_hi)
            level = 1'b1;
        else
            level = pwm_in_window(16'(count), 16'(rise_sh), 16'(fall_sh));
    end

    // Register the output, with polarity applied and the idle level in sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out <= 1'b0;
        else if (sleep)
            out <= invert;
        else
            out <= level ^ invert;
    end
endmodule

// File: rtl/edge_pwm_bank.sv
// Module: top of the multichannel edge-compare PWM engine.
// One shared timebase feeds NUM_CH channel slices. Rise and fall counts arrive
// packed, with channel i in bits [i*CNT_W +: CNT_W].
// Assumes CNT_W <= 16 and PRE_MIN fits in PRE_W bits.
module edge_pwm_bank #(
    parameter int NUM_CH  = 16,
    parameter int CNT_W   = 12,
    parameter int PRE_W   = 8,
    parameter int PRE_MIN = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep,
    input  logic [PRE_W-1:0]        prescale,
    input  logic                    invert,
    input  logic [NUM_CH*CNT_W-1:0] rise_cnt,
    input  logic [NUM_CH*CNT_W-1:0] fall_cnt,
    input  logic [NUM_CH-1:0]       force_hi,
    input  logic [NUM_CH-1:0]       force_lo,
    output logic [NUM_CH-1:0]       pwm_out
);
    logic [CNT_W-1:0] count;
    logic             wrap;

    // Shared prescaler and period counter.
    pwm_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_MIN(PRE_MIN)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .prescale (prescale),
        .count    (count),
        .wrap     (wrap)
    );

    // One compare slice per channel.
    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .sleep    (sleep),
            .invert   (invert),
            .wrap     (wrap),
            .count    (count),
            .rise_in  (rise_cnt[gi*CNT_W +: CNT_W]),
            .fall_in  (fall_cnt[gi*CNT_W +: CNT_W]),
            .force_hi (force_hi[gi]),
            .force_lo (force_lo[gi]),
            .out      (pwm_out[gi])
        );
    end
endmodule

// File: rtl/edge_pwm_bank_chk.sv
// Checker: temporal properties of the PWM bank, bound to the top module.
// Observes the ports and the shared counter.
module edge_pwm_bank_chk #(
    parameter int NUM_CH  = 16,
    parameter int CNT_W   = 12,
    parameter int PRE_W   = 8,
    parameter int PRE_MIN = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic              invert,
    input logic [NUM_CH-1:0] force_hi,
    input logic [NUM_CH-1:0] force_lo,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [CNT_W-1:0]  count
);
    logic [2:0]       since_rst;
    logic [PRE_W+1:0] dwell;
    logic [CNT_W-1:0] last_cnt;

    // Cycles since reset release, saturating, so $past never reaches before reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 3'd4)
            since_rst <= since_rst + 1'b1;
    end

    // Count the edges on which the counter held its value.
    always_ff @(posedge clk) begin
        last_cnt <= count;
        if (!rst_n || sleep || count != last_cnt)
            dwell <= '0;
        else if (dwell != '1)
            dwell <= dwell + 1'b1;
    end

    // R5: a hold-low flag forces the unflipped level low.
    p_force_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> (((pwm_out ^ {NUM_CH{$past(invert)}}) & $past(force_lo)) == '0));

    // R6: hold-high without hold-low forces the unflipped level high.
    p_force_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep |=> (((~(pwm_out ^ {NUM_CH{$past(invert)}})) & $past(force_hi & ~force_lo)) == '0));

    // R9: sleep drives every output to the polarity level.
    p_sleep_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (pwm_out == {NUM_CH{$past(invert)}}));

    // R1: outside sleep the counter only ever moves forward by one.
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(count) && !$past(sleep)) |-> (count == CNT_W'($past(count) + 1'b1)));

    // R2: the clamp keeps every counter value for at least PRE_MIN+1 edges.
    p_min_dwell_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4 && !$stable(count) && !$past(sleep)) |->
        ($past(count, 2) == $past(count, 1) && $past(count, 3) == $past(count, 1)));

    // R2: no counter value is held longer than the largest prescale allows.
    p_max_dwell_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dwell <= (PRE_W+2)'(2**PRE_W + 1));
endmodule

bind edge_pwm_bank edge_pwm_bank_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .PRE_W  (PRE_W),
    .PRE_MIN(PRE_MIN)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .invert   (invert),
    .force_hi (force_hi),
    .force_lo (force_lo),
    .pwm_out  (pwm_out),
    .count    (count)
);

// File: tb/test_edge_pwm_bank.sv
// Bench: directed corner cases plus seeded random configurations, checked
// every cycle against a reference model and per period against a duty formula.
module test_edge_pwm_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;
    localparam int CW  = 5;
    localparam int PW  = 8;
    localparam int M   = 2**CW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sleep = 1'b1;
    logic [PW-1:0]     prescale = 8'd3;
    logic              invert = 1'b0;
    logic [NCH*CW-1:0] rise_cnt;
    logic [NCH*CW-1:0] fall_cnt;
    logic [NCH-1:0]    force_hi = '0;
    logic [NCH-1:0]    force_lo = '0;
    logic [NCH-1:0]    pwm_out;

    logic [CW-1:0] live_r [NCH];
    logic [CW-1:0] live_f [NCH];
    logic [CW-1:0] sh_r   [NCH];
    logic [CW-1:0] sh_f   [NCH];
    int            hi_cnt [NCH];

    int    checks = 0;
    int    errors = 0;
    int    j = 0;
    bit    meas = 1'b0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack the per-channel settings onto the flat buses.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            rise_cnt[i*CW +: CW] = live_r[i];
            fall_cnt[i*CW +: CW] = live_f[i];
        end
    end

    edge_pwm_bank #(.NUM_CH(NCH), .CNT_W(CW), .PRE_W(PW), .PRE_MIN(3)) i_edge_pwm_bank (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .prescale(prescale), .invert(invert),
        .rise_cnt(rise_cnt), .fall_cnt(fall_cnt), .force_hi(force_hi), .force_lo(force_lo),
        .pwm_out(pwm_out)
    );

    function automatic int eff_p(input logic [PW-1:0] p);
        return ((p < 3) ? 3 : int'(p)) + 1;
    endfunction

    // Expected unflipped level from R3 to R6.
    function automatic logic ref_level(input int c, input int r, input int f, input logic fh, input logic fl);
        if (fl) return 1'b0;
        if (fh) return 1'b1;
        if (r < f) return (c >= r) && (c < f);
        if (r > f) return (c >= r) || (c < f);
        return 1'b0;
    endfunction

    task automatic check(input logic [NCH-1:0] act, input logic [NCH-1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pwm_out=%h expected %h (j=%0d)", req, act, exp, j);
        end
    endtask

    // One clock: advance the reference model and compare outputs.
    task automatic step();
        logic          sl;
        logic [NCH-1:0] exp;
        int            p;
        int            c;
        sl = sleep;
        p  = eff_p(prescale);
        @(posedge clk);
        #1;
        if (sl) begin
            j = 0;
            for (int i = 0; i < NCH; i++) begin sh_r[i] = live_r[i]; sh_f[i] = live_f[i]; end
            exp = {NCH{invert}};
        end else begin
            j++;
            c = ((j - 1) / p) % M;
            for (int i = 0; i < NCH; i++)
                exp[i] = ref_level(c, sh_r[i], sh_f[i], force_hi[i], force_lo[i]) ^ invert;
            if ((j % p) == 0 && c == M - 1)
                for (int i = 0; i < NCH; i++) begin sh_r[i] = live_r[i]; sh_f[i] = live_f[i]; end
        end
        check(pwm_out, exp, tag);
        if (meas)
            for (int i = 0; i < NCH; i++) hi_cnt[i] += int'(pwm_out[i] ^ invert);
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic park_release();
        sleep = 1'b1;
        step();
        sleep = 1'b0;
    endtask

    // Run two periods from release; check high time of the second against R1/R3-R6.
    task automatic duty_run(input string req);
        int p;
        int w;
        int expv;
        p   = eff_p(prescale);
        tag = req;
        park_release();
        steps(M * p);
        for (int i = 0; i < NCH; i++) hi_cnt[i] = 0;
        meas = 1'b1;
        steps(M * p);
        meas = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            w = int'(CW'(live_f[i] - live_r[i]));
            if (force_lo[i]) expv = 0;
            else if (force_hi[i]) expv = M * p;
            else expv = w * p;
            checks++;
            if (hi_cnt[i] != expv) begin
                errors++;
                $display("FAIL %s: channel %0d high clocks=%0d expected %0d", req, i, hi_cnt[i], expv);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin live_r[i] = '0; live_f[i] = '0; end
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1;
        check(pwm_out, '0, "R9 reset");
        rst_n = 1'b1;

        // R9 with R7: sleep drives outputs to the polarity level.
        invert = 1'b1;
        tag = "R9";
        sleep = 1'b1;
        steps(3);
        invert = 1'b0;
        steps(2);

        // R3: staggered non-wrapping windows at prescale 3.
        prescale = 8'd3;
        for (int i = 0; i < NCH; i++) begin live_r[i] = CW'(i); live_f[i] = CW'(i + 7); end
        duty_run("R3");

        // R4: wrapping windows and equal counts.
        for (int i = 0; i < NCH; i++) begin live_r[i] = CW'(20 + i); live_f[i] = CW'(i % 6); end
        live_r[3] = 5'd9;  live_f[3] = 5'd9;
        live_r[4] = 5'd0;  live_f[4] = 5'd0;
        live_r[5] = 5'd31; live_f[5] = 5'd0;
        duty_run("R4");

        // R2: prescale below the floor behaves as the floor.
        prescale = 8'd0;
        duty_run("R2");
        prescale = 8'd2;
        duty_run("R2");

        // R5 and R6: overrides, including both flags set together.
        prescale = 8'd4;
        force_lo = 16'h00F3;
        force_hi = 16'h0F30;
        duty_run("R5");
        tag = "R6";
        force_lo = 16'h0000;
        force_hi = 16'hA5A5;
        steps(50);

        // R10: a flag change shows one clock after it is sampled.
        tag = "R10";
        force_lo = 16'hFFFF;
        step();
        check(pwm_out, 16'h0000, "R10 force_lo next edge");
        force_lo = 16'h0000;
        force_hi = 16'h0000;
        steps(3);

        // R7: global inversion.
        invert = 1'b1;
        duty_run("R7");
        invert = 1'b0;

        // R8: mid-period update only lands at the rollover.
        prescale = 8'd3;
        for (int i = 0; i < NCH; i++) begin live_r[i] = 5'd2; live_f[i] = 5'd6; end
        tag = "R8";
        park_release();
        steps(M * 4 + 40);
        for (int i = 0; i < NCH; i++) begin live_r[i] = 5'd10; live_f[i] = 5'd30; end
        steps(M * 4 * 2);

        // R1: the largest prescale, one long period.
        prescale = 8'd255;
        for (int i = 0; i < NCH; i++) begin live_r[i] = CW'(2 * i); live_f[i] = CW'(2 * i + 3); end
        duty_run("R1");

        // Seeded random configurations across all features.
        for (int t = 0; t < 10; t++) begin
            prescale = PW'($urandom_range(0, 9));
            invert   = 1'($urandom_range(0, 1));
            force_hi = NCH'($urandom) & NCH'($urandom);
            force_lo = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            for (int i = 0; i < NCH; i++) begin
                live_r[i] = CW'($urandom);
                live_f[i] = CW'($urandom);
            end
            duty_run("R3 R4 R5 R6 R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule